// File: doc/BRIEF.md
# Serial Memory Status Register Controller

This block is the status-register front end of a serial memory slave that runs in SPI mode 0. It watches chip select, serial clock and serial data in, all brought into the system clock domain through a synchroniser. It decodes three one-byte instructions: set write enable, read status and write status. It holds the write-enable latch, the busy flag, two block-protect bits and a write-disable bit. The two protect bits are also driven to the memory array on `blk_prot`.

A status write is accepted only when four conditions hold. The write-enable latch must be set. The block must not be busy. Hardware protection must not be active. Chip select must rise in the single window after the eighth data bit and before any ninth clock. An accepted write starts a self-timed cycle of `TW_CYCLES` system clocks. The new protection bits take effect only when that cycle ends.

The command path is one state machine with these states: `ST_IDLE`, `ST_OPCODE`, `ST_WEN_TAIL`, `ST_WSR_DATA`, `ST_WSR_TAIL`, `ST_RSR_OUT` and `ST_DISCARD`. It moves between them as follows:
- A falling chip select takes `ST_IDLE` to `ST_OPCODE`.
- The eighth opcode bit leads to `ST_WEN_TAIL`, `ST_WSR_DATA`, `ST_RSR_OUT` or `ST_DISCARD`, depending on the opcode.
- The eighth data bit takes `ST_WSR_DATA` to `ST_WSR_TAIL`.
- Any further clock in either tail state leads to `ST_DISCARD`.
- A rising chip select returns every state to `ST_IDLE`. It commits the instruction only when it arrives in a tail state.

The timer has its own state machine. `CORE_READY` moves to `CORE_BUSY` when a status write starts. It moves back when the count runs out.

Top module: `spi_sr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `blk_prot` is 0 and `spi_miso` is 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) only if chip select rises after exactly 8 bits. A ninth clock cancels it.
- R3: Opcode 0x05 shifts out the status byte MSB first, changing on falling serial clock edges. The byte repeats while chip select stays low. The layout is: bit 7 write-disable, bits 3:2 block-protect, bit 1 write-enable latch, bit 0 busy. `spi_miso` is 0 outside a read.
- R4: A write-status instruction (opcode 0x01 followed by one data byte) is ignored when the write-enable latch is clear.
- R5: A write-status instruction commits only if chip select rises after the 8th data bit and before a 9th rising clock. With 7 bits or 9 bits it is discarded.
- R6: A committed write sets the busy bit for `TW_CYCLES` clocks. When the cycle ends, busy and the write-enable latch both clear.
- R7: The write-disable and block-protect bits, and `blk_prot`, keep their old values throughout the busy cycle and update when it ends. Status can be read while busy.
- R8: Only data bits 7, 3 and 2 are stored. Status bits 6:4 always read 0, and data bits 6:4 and 1:0 have no effect.
- R9: When the write-disable bit is 1 and `wp_n` is low, a write-status instruction is ignored. With `wp_n` high it is accepted.
- R10: A write-enable or write-status instruction that ends while busy is ignored.
- R11: An unknown opcode is discarded and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in, sampled on rising edges |
| spi_miso | output | 1 | Serial data out, updated on falling edges |
| wp_n | input | 1 | Write-protect pin, active low |
| blk_prot | output | 2 | Block-protect bits to the memory array |

## Verification
Two functions can fall in the same system clock: the busy timer reaching its end and the read path loading the status snapshot for the next output byte. A snapshot taken in that clock must hold either the complete old value or the complete new value, never a mix. To provoke this, the bench opens one long read frame just after a write commits and keeps it running past the end of the cycle. Every byte in the frame must equal either the busy-with-old-bits value or the idle-with-new-bits value. Once the new value has appeared, the old one must never return.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WEN_TAIL,
        ST_WSR_DATA,
        ST_WSR_TAIL,
        ST_RSR_OUT,
        ST_DISCARD
    } cmd_state_t;

    typedef enum logic {
        CORE_READY,
        CORE_BUSY
    } core_state_t;

    localparam logic [7:0] OP_WEN = 8'h06;
    localparam logic [7:0] OP_RSR = 8'h05;
    localparam logic [7:0] OP_WSR = 8'h01;

    typedef struct packed {
        logic       srwd;
        logic [1:0] bp;
        logic       wel;
        logic       wip;
    } sr_fields_t;

    function automatic logic [7:0] pack_status(sr_fields_t f);
        return {f.srwd, 3'b000, f.bp, f.wel, f.wip};
    endfunction

endpackage

// File: rtl/sr_pin_sync.sv
module sr_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= rst_val;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/sr_status_core.sv
module sr_status_core
    import sr_pkg::*;
#(
    parameter int TW_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wen_commit,
    input  logic       wsr_start,
    input  logic [7:0] wsr_data,
    input  logic       wp_s,
    output sr_fields_t cur
);
    localparam int CW = $clog2(TW_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(TW_CYCLES - 1);

    core_state_t state;
    logic [CW-1:0] cnt;
    logic       pend_srwd;
    logic [1:0] pend_bp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= CORE_READY;
            cnt       <= '0;
            cur       <= '0;
            pend_srwd <= 1'b0;
            pend_bp   <= 2'b00;
        end else begin
            unique case (state)
                CORE_READY: begin
                    if (wsr_start) begin
                        pend_srwd <= wsr_data[7];
                        pend_bp   <= wsr_data[3:2];
                        cnt       <= LOAD;
                        cur.wip   <= 1'b1;
                        state     <= CORE_BUSY;
                    end else if (wen_commit) begin
                        cur.wel <= 1'b1;
                    end
                end
                CORE_BUSY: begin
                    if (cnt == '0) begin
                        cur.srwd <= pend_srwd;
                        cur.bp   <= pend_bp;
                        cur.wel  <= 1'b0;
                        cur.wip  <= 1'b0;
                        state    <= CORE_READY;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= CORE_READY;
            endcase
        end
    end

    assert_start_has_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_start |-> cur.wel);
    assert_start_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wsr_start || wen_commit) |-> !cur.wip);
    assert_hw_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wsr_start |-> !(cur.srwd && !wp_s));
    assert_wel_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur.wip) |-> !cur.wel);
    assert_prot_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.bp != $past(cur.bp) || cur.srwd != $past(cur.srwd)) |-> ($past(cur.wip) && !cur.wip));
endmodule

// File: rtl/sr_cmd_fsm.sv
module sr_cmd_fsm
    import sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csn_s,
    input  logic       sck_s,
    input  logic       mosi_s,
    input  logic       wp_s,
    input  sr_fields_t cur,
    output logic       wen_commit,
    output logic       wsr_start,
    output logic [7:0] wsr_data,
    output logic       miso
);
    cmd_state_t state, state_n;
    logic       sck_q, csn_q;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic [2:0] out_idx;
    logic [7:0] snap;
    logic       miso_q;
    logic [7:0] stat_byte;
    logic [7:0] op_full;

    wire sck_rise = sck_s & ~sck_q;
    wire sck_fall = ~sck_s & sck_q;
    wire cs_fall  = ~csn_s & csn_q;
    wire cs_rise  = csn_s & ~csn_q;

    assign stat_byte = pack_status(cur);
    assign op_full   = {shreg[6:0], mosi_s};

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (cs_fall) state_n = ST_OPCODE;
            ST_OPCODE: begin
                if (cs_rise) state_n = ST_IDLE;
                else if (sck_rise && bit_cnt == 3'd7) begin
                    unique case (op_full)
                        OP_WEN:  state_n = ST_WEN_TAIL;
                        OP_WSR:  state_n = ST_WSR_DATA;
                        OP_RSR:  state_n = ST_RSR_OUT;
                        default: state_n = ST_DISCARD;
                    endcase
                end
            end
            ST_WEN_TAIL: begin
                if (cs_rise) state_n = ST_IDLE;
                else if (sck_rise) state_n = ST_DISCARD;
            end
            ST_WSR_DATA: begin
                if (cs_rise) state_n = ST_IDLE;
                else if (sck_rise && bit_cnt == 3'd7) state_n = ST_WSR_TAIL;
            end
            ST_WSR_TAIL: begin
                if (cs_rise) state_n = ST_IDLE;
                else if (sck_rise) state_n = ST_DISCARD;
            end
            ST_RSR_OUT:  if (cs_rise) state_n = ST_IDLE;
            ST_DISCARD:  if (cs_rise) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sck_q   <= 1'b0;
            csn_q   <= 1'b1;
            bit_cnt <= 3'd0;
            shreg   <= 8'h00;
        end else begin
            state <= state_n;
            sck_q <= sck_s;
            csn_q <= csn_s;
            if (cs_fall) begin
                bit_cnt <= 3'd0;
            end else if (sck_rise && (state == ST_OPCODE || state == ST_WSR_DATA)) begin
                shreg   <= op_full;
                bit_cnt <= bit_cnt + 3'd1;
            end
        end
    end

    always_comb begin
        wen_commit = (state == ST_WEN_TAIL) && cs_rise && !cur.wip;
        wsr_start  = (state == ST_WSR_TAIL) && cs_rise && cur.wel && !cur.wip
                     && !(cur.srwd && !wp_s);
        wsr_data   = shreg;
        miso       = miso_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q  <= 1'b0;
            out_idx <= 3'd7;
            snap    <= 8'h00;
        end else if (state != ST_RSR_OUT) begin
            miso_q  <= 1'b0;
            out_idx <= 3'd7;
        end else if (sck_fall) begin
            if (out_idx == 3'd7) begin
                snap   <= stat_byte;
                miso_q <= stat_byte[7];
            end else begin
                miso_q <= snap[out_idx];
            end
            out_idx <= out_idx - 3'd1;
        end
    end

    assert_miso_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RSR_OUT) |=> (miso == 1'b0));
    assert_commit_one_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_commit && wsr_start));
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
    import sr_pkg::*;
#(
    parameter int TW_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic       wp_n,
    output logic [1:0] blk_prot
);
    localparam int NPINS = 4;

    logic [NPINS-1:0] pins_s;
    logic       wen_commit, wsr_start;
    logic [7:0] wsr_data;
    sr_fields_t cur;

    sr_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (4'b1100),
        .d_async ({wp_n, spi_csn, spi_sck, spi_mosi}),
        .q_sync  (pins_s)
    );

    sr_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_s      (pins_s[2]),
        .sck_s      (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .wp_s       (pins_s[3]),
        .cur        (cur),
        .wen_commit (wen_commit),
        .wsr_start  (wsr_start),
        .wsr_data   (wsr_data),
        .miso       (spi_miso)
    );

    sr_status_core #(.TW_CYCLES(TW_CYCLES)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen_commit (wen_commit),
        .wsr_start  (wsr_start),
        .wsr_data   (wsr_data),
        .wp_s       (pins_s[3]),
        .cur        (cur)
    );

    assign blk_prot = cur.bp;
endmodule

// File: tb/sim_spi_sr_ctrl.sv
module sim_spi_sr_ctrl;
    localparam int TW   = 600;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, wp_n = 1'b1;
    logic spi_miso;
    logic [1:0] blk_prot;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    spi_sr_ctrl #(.TW_CYCLES(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wp_n(wp_n), .blk_prot(blk_prot)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_n(input logic [7:0] b, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = b[i];
            wait_clk(HALF);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] rx;
        cs_low(); xfer_n(op, 8, rx); cs_high();
    endtask

    task automatic wsr(input logic [7:0] d, input int nbits);
        logic [7:0] rx;
        cs_low(); xfer_n(8'h01, 8, rx);
        if (nbits > 8) begin
            xfer_n(d, 8, rx); xfer_n(8'h00, nbits - 8, rx);
        end else begin
            xfer_n(d, nbits, rx);
        end
        cs_high();
    endtask

    // driver: pushes expected bytes, then the captured bytes for the monitor
    task automatic rdsr(input int nbytes, input logic [7:0] exp, input string req);
        logic [7:0] rx;
        cs_low(); xfer_n(8'h05, 8, rx);
        for (int k = 0; k < nbytes; k++) begin
            exp_q.push_back(exp);
            tag_q.push_back(req);
            xfer_n(8'h00, 8, rx);
            act_q.push_back(rx);
        end
        cs_high();
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
                chk(t, a, e);
            end
        end
    end

    initial begin
        wait_clk(200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        bit seen_new;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 miso", {7'd0, spi_miso}, 8'h00);
        chk("R1 blk_prot", {6'd0, blk_prot}, 8'h00);
        rdsr(1, 8'h00, "R1 status");

        wsr(8'h8C, 8);                       // no write enable
        rdsr(1, 8'h00, "R4 ignored without enable");

        cs_low(); xfer_n(8'h06, 8, rx); xfer_n(8'h00, 1, rx); cs_high();
        rdsr(1, 8'h00, "R2 nine-bit enable cancelled");
        cmd(8'h06);
        rdsr(1, 8'h02, "R2 enable set");

        wsr(8'h8C, 7);
        rdsr(1, 8'h02, "R5 seven data bits discarded");
        wsr(8'h8C, 9);
        rdsr(1, 8'h02, "R5 nine data bits discarded");

        // commit 0x7F: only bp=11 stored, other bits ignored (R8)
        wsr(8'h7F, 8);
        chk("R7 blk_prot held while busy", {6'd0, blk_prot}, 8'h00);
        rdsr(2, 8'h03, "R6 R7 R3 busy read repeats");
        // long poll frame straddles end of cycle
        seen_new = 0;
        cs_low(); xfer_n(8'h05, 8, rx);
        for (int k = 0; k < 4; k++) begin
            xfer_n(8'h00, 8, rx);
            checks++;
            if (!(rx == 8'h03 && !seen_new) && rx != 8'h0C) begin
                errors++;
                $display("FAIL R6 poll byte: got %02h expected 03 then 0C", rx);
            end
            if (rx == 8'h0C) seen_new = 1;
        end
        cs_high();
        chk("R6 cycle ended in poll", {7'd0, seen_new}, 8'h01);
        wait_clk(TW);
        rdsr(1, 8'h0C, "R8 R6 completed write");
        chk("R7 blk_prot updated", {6'd0, blk_prot}, 8'h03);

        cmd(8'h04);
        cmd(8'hAB);
        rdsr(1, 8'h0C, "R11 unknown opcodes");

        cmd(8'h06);
        wsr(8'h84, 8);
        wait_clk(TW + 50);
        rdsr(1, 8'h84, "R9 accepted with pin high");
        chk("R7 blk_prot", {6'd0, blk_prot}, 8'h01);

        wp_n = 1'b0;
        cmd(8'h06);
        wsr(8'h00, 8);
        wait_clk(TW + 50);
        rdsr(1, 8'h86, "R9 hardware protected");

        wp_n = 1'b1;
        wsr(8'h00, 8);
        wsr(8'h8C, 8);                       // while busy
        cmd(8'h06);                          // while busy
        wait_clk(TW + 50);
        rdsr(1, 8'h00, "R10 writes while busy ignored");
        chk("R10 blk_prot", {6'd0, blk_prot}, 8'h00);
        chk("R3 miso idle", {7'd0, spi_miso}, 8'h00);

        wait_clk(10);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule